// File: doc/BRIEF.md
# Supply-Cut Pulse and Delayed Glitch Trigger Sequencer

This block cuts a target's supply for an exact number of clock cycles and then fires a trigger for a downstream glitch generator. The supply-control output idles high, and an external analog switch gates the supply from it. A single start command drives the output low for a programmed number of cycles. When the output returns high, the block counts a second programmed number of cycles and then emits a one-cycle trigger strobe. Both lengths are counted in fabric clock cycles, so host latency never reaches the timing. The interval from supply return to glitch is therefore identical on every run, and one start command produces both the supply cut and the glitch trigger.

Configuration comes through a small write port with three decoded addresses: pulse length, trigger offset and control. The sequence captures both lengths when it starts. Status outputs report whether a run is in progress, whether the last run has completed, and whether a start was refused because a run was already active.

Top module: `pwrcut_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with `supply_n` high and `glitch_trig`, `busy`, `done` and `overrun` low. This also applies when reset arrives in the middle of a run.
- R2: A write of a value with bit 0 set to address 2 starts a run if the block is idle. `supply_n` goes low in the cycle after that edge and stays low for exactly N cycles, where N is the value at address 0.
- R3: A pulse length of 0 gives a low time of exactly one cycle.
- R4: The trigger offset K is the value at address 1. `glitch_trig` is high K cycles after the cycle in which `supply_n` returns high. With K = 0 it is high in that same cycle.
- R5: `glitch_trig` is high for exactly one cycle per run.
- R6: `busy` is high from the cycle after the start through the trigger cycle. `done` rises in the cycle after the trigger and stays high until the next accepted start clears it.
- R7: The pulse length and trigger offset are captured at the start. Writes to addresses 0 and 1 during a run do not change that run, and the next run uses the new values.
- R8: A start request that arrives while `busy` is high is ignored and sets the sticky `overrun` output. The next accepted start clears `overrun`.
- R9: A write to address 3, or a write to address 2 with bit 0 clear, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | 0 = pulse length, 1 = trigger offset, 2 = control (bit 0 starts) |
| cfg_wdata | input | CNT_W | Write data |
| supply_n | output | 1 | Supply-control line, low while the target supply is cut |
| glitch_trig | output | 1 | One-cycle strobe for the glitch generator |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished, held until the next start |
| overrun | output | 1 | Sticky flag: a start was refused during a run |

## Verification
The bench builds the block with `CNT_W = 8`. This makes an exhaustive sweep of pulse lengths 0 to 5 against trigger offsets 0 to 4 practical, covering the zero-length pulse and the zero-offset trigger together. At this width the all-ones limit of 255 for both registers is also within reach, which exercises the counter at full range. The same small build lets the bench inject writes and start requests at chosen cycles of a run, and apply reset partway through a pulse.

// File: rtl/pwrcut_pkg.sv
// Package: shared types and address decode values for the supply-cut sequencer.
// Assumes a two-bit configuration address space.
package pwrcut_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    localparam logic [1:0] ADDR_LEN  = 2'd0;
    localparam logic [1:0] ADDR_OFS  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int CTRL_GO_BIT = 0;

endpackage

// File: rtl/pwrcut_cfg.sv
// Module: configuration registers and start decode.
// Holds the pulse length and trigger offset written by the host and decodes
// a start request from the control address. The start request is
// combinational; the sequencer registers everything downstream of it.
// Assumes a single write port with one write per cycle.
module pwrcut_cfg
    import pwrcut_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] len_q,
    output logic [CNT_W-1:0] ofs_q,
    output logic             start_req
);

    // Store the host-written pulse length and trigger offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            ofs_q <= '0;
        end else if (we) begin
            if (addr == ADDR_LEN) len_q <= wdata;
            if (addr == ADDR_OFS) ofs_q <= wdata;
        end
    end

    // Decode a start request from a control write with the go bit set.
    always_comb begin
        start_req = we && (addr == ADDR_CTRL) && wdata[CTRL_GO_BIT];
    end

endmodule

// File: rtl/pwrcut_downcnt.sv
// Module: loadable down-counter shared by the pulse and offset phases.
// Load has priority over decrement. Assumes the controller never asks for a
// decrement at zero.
module pwrcut_downcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] q,
    output logic             is_zero,
    output logic             is_one
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Hold the count: load, decrement, or keep.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load)   q <= load_val;
        else if (dec)    q <= q - ONE;
    end

    // Flag the terminal values the sequencer steers on.
    always_comb begin
        is_zero = (q == '0);
        is_one  = (q == ONE);
    end

    // R2
    cnt_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> !is_zero);

endmodule

// File: rtl/pwrcut_fsm.sv
// Module: sequencer for the supply-cut pulse and the delayed trigger.
// Captures the configuration at start, holds supply_n low for max(len,1)
// cycles, then fires the trigger ofs cycles after the release edge (in the
// release cycle when ofs is 0). Assumes start_req lasts one cycle per
// request.
module pwrcut_fsm
    import pwrcut_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] len_q,
    input  logic [CNT_W-1:0] ofs_q,
    output logic             supply_n,
    output logic             glitch_trig,
    output logic             busy,
    output logic             done,
    output logic             overrun
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       state;
    logic [CNT_W-1:0] ofs_lat;
    logic             cnt_load;
    logic             cnt_dec;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;
    logic             cnt_one;

    pwrcut_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .q        (cnt_q),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    // Report a run in progress from the state alone.
    always_comb begin
        busy = (state != ST_IDLE);
    end

    // Steer the counter: load a phase length or step it down.
    always_comb begin
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        case (state)
            ST_IDLE: begin
                if (start_req) begin
                    cnt_load = 1'b1;
                    cnt_val  = (len_q == '0) ? '0 : (len_q - ONE);
                end
            end
            ST_LOW: begin
                if (cnt_zero) begin
                    cnt_load = 1'b1;
                    cnt_val  = ofs_lat;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_WAIT: begin
                cnt_dec = !glitch_trig && !cnt_one && !cnt_zero;
            end
            default: begin
                cnt_load = 1'b0;
            end
        endcase
    end

    // Advance the sequence and update the output and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            supply_n    <= 1'b1;
            glitch_trig <= 1'b0;
            done        <= 1'b0;
            overrun     <= 1'b0;
            ofs_lat     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state    <= ST_LOW;
                        supply_n <= 1'b0;
                        done     <= 1'b0;
                        overrun  <= 1'b0;
                        ofs_lat  <= ofs_q;
                    end
                end
                ST_LOW: begin
                    if (start_req) overrun <= 1'b1;
                    if (cnt_zero) begin
                        state       <= ST_WAIT;
                        supply_n    <= 1'b1;
                        glitch_trig <= (ofs_lat == '0);
                    end
                end
                ST_WAIT: begin
                    if (start_req) overrun <= 1'b1;
                    if (glitch_trig) begin
                        glitch_trig <= 1'b0;
                        done        <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (cnt_one) begin
                        glitch_trig <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    supply_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_n |-> busy);

    // R4
    trig_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_trig |-> supply_n);

    // R5
    trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_trig |=> !glitch_trig);

    // R6
    done_follows_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_trig |=> (done && !busy));

    // R6
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && busy) |=> overrun);

endmodule

// File: rtl/pwrcut_seq.sv
// Module: top of the supply-cut pulse and delayed glitch trigger sequencer.
// Connects the configuration registers to the sequencer. All timing is in
// clk cycles. Assumes supply_n drives an external switch that cuts the
// target supply while low.
module pwrcut_seq
    import pwrcut_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic             supply_n,
    output logic             glitch_trig,
    output logic             busy,
    output logic             done,
    output logic             overrun
);

    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] ofs_q;
    logic             start_req;

    pwrcut_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .len_q     (len_q),
        .ofs_q     (ofs_q),
        .start_req (start_req)
    );

    pwrcut_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .len_q       (len_q),
        .ofs_q       (ofs_q),
        .supply_n    (supply_n),
        .glitch_trig (glitch_trig),
        .busy        (busy),
        .done        (done),
        .overrun     (overrun)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (supply_n && !glitch_trig && !busy && !done && !overrun));

endmodule

// File: tb/sim_pwrcut_seq.sv
// Bench: sweeps pulse length and offset, checks timing per cycle arithmetically.
module sim_pwrcut_seq;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_addr = 2'd0;
    logic [W-1:0] cfg_wdata = '0;
    logic supply_n, glitch_trig, busy, done, overrun;

    int n_checks = 0;
    int n_fail = 0;

    pwrcut_seq #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .supply_n(supply_n), .glitch_trig(glitch_trig),
        .busy(busy), .done(done), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Starts a run and samples every cycle after the start edge.
    // inj_c >= 0 drives one write in sample cycle inj_c.
    task automatic run(input int n_exp, input int k_exp, input string tag,
                       input int inj_c, input logic [1:0] inj_a, input int inj_d);
        int first_low = -1, low_cnt = 0, trig_at = -1, trig_cnt = 0;
        int busy_bad = 0;
        int last = n_exp + k_exp + 3;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = W'(1);
        for (int c = 0; c <= last; c++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (!supply_n) begin
                low_cnt++;
                if (first_low < 0) first_low = c;
            end
            if (glitch_trig) begin
                trig_cnt++;
                if (trig_at < 0) trig_at = c;
            end
            if (busy != (c <= n_exp + k_exp)) busy_bad++;
            if (c == inj_c) begin
                cfg_we = 1'b1; cfg_addr = inj_a; cfg_wdata = W'(inj_d);
            end
        end
        check(first_low == 0, {"R2 first low cycle ", tag}, first_low, 0);
        check(low_cnt == n_exp, {"R2/R3 low length ", tag}, low_cnt, n_exp);
        check(trig_at == n_exp + k_exp, {"R4 trigger cycle ", tag}, trig_at, n_exp + k_exp);
        check(trig_cnt == 1, {"R5 trigger width ", tag}, trig_cnt, 1);
        check(busy_bad == 0, {"R6 busy window ", tag}, busy_bad, 0);
        check(done == 1'b1, {"R6 done held ", tag}, int'(done), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(supply_n && !glitch_trig && !busy && !done && !overrun,
              "R1 reset outputs", {supply_n, glitch_trig, busy, done, overrun}, 5'b10000);

        // R2 R3 R4 R5 R6 exhaustive small sweep
        for (int n = 0; n <= 5; n++) begin
            for (int k = 0; k <= 4; k++) begin
                wr(2'd0, n);
                wr(2'd1, k);
                run((n == 0) ? 1 : n, k, $sformatf("n=%0d k=%0d", n, k), -1, 2'd0, 0);
            end
        end

        // R2 R4 full-range counts
        wr(2'd0, 255); wr(2'd1, 255);
        run(255, 255, "n=255 k=255", -1, 2'd0, 0);

        // R7 writes during a run are captured for the next run only
        wr(2'd0, 3); wr(2'd1, 2);
        run(3, 2, "R7 len write mid-run", 1, 2'd0, 7);
        wr(2'd0, 3); wr(2'd1, 2);
        run(3, 2, "R7 ofs write mid-run", 1, 2'd1, 0);
        wr(2'd0, 7);
        run(7, 0, "R7 new values", -1, 2'd0, 0);

        // R8 start during run is ignored and sets overrun
        wr(2'd0, 4); wr(2'd1, 3);
        run(4, 3, "R8 start mid-run", 2, 2'd2, 1);
        check(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
        run(4, 3, "R8 next run", -1, 2'd0, 0);
        check(overrun == 1'b0, "R8 overrun cleared by start", int'(overrun), 0);

        // R9 address 3 and control without go bit do not start
        wr(2'd3, 1);
        @(negedge clk);
        check(!busy && supply_n, "R9 addr 3 no start", int'(busy), 0);
        wr(2'd2, 2);
        @(negedge clk);
        check(!busy && supply_n, "R9 go bit clear no start", int'(busy), 0);

        // R1 reset in the middle of a pulse
        wr(2'd0, 20); wr(2'd1, 1);
        wr(2'd2, 1);
        repeat (3) @(negedge clk);
        check(!supply_n, "R1 pulse running before reset", int'(supply_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(supply_n && !glitch_trig && !busy && !done && !overrun,
              "R1 mid-run reset", {supply_n, glitch_trig, busy, done, overrun}, 5'b10000);
        rst_n = 1'b1;
        repeat (25) @(negedge clk);
        check(supply_n && !glitch_trig && !busy, "R1 stays idle after reset",
              {supply_n, glitch_trig, busy}, 3'b100);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule